// File: doc/BRIEF.md
# Write-Only Two-Wire Clock Enable Controller

This block fans one reference clock out to seven gated copies. A two-wire serial master can switch each copy on or off. The serial side is a write-only slave. A fast system clock oversamples the bus lines, and the slave detects start and stop conditions. It acknowledges a single fixed write address, then expects two header bytes whose contents it ignores. After that it loads data bytes in order into two 8-bit control registers. There is no sub-addressing. Every transfer loads from control byte 0, so changing byte 1 means sending byte 0 again. Nothing can be read back.

Each register bit that drives an output crosses into the reference-clock domain. It takes effect only while the reference clock is low. An output that is switched on or off therefore never produces a shortened pulse.

The receiver is one state machine with eight states:
- ST_IDLE: waits for a start.
- ST_ADDR: shifts in the address byte.
- ST_ADDR_ACK: drives the acknowledge for the address.
- ST_HDR and ST_HDR_ACK: take and acknowledge the header bytes.
- ST_DATA and ST_DATA_ACK: take and acknowledge the data bytes.
- ST_SKIP: ignores the bus after an address it does not accept.

The transitions are:
- A start leads from any state to ST_ADDR.
- A stop leads from any state to ST_IDLE.
- ST_ADDR moves to ST_ADDR_ACK on a match, or to ST_SKIP on a mismatch, at the serial-clock fall after the eighth bit.
- Each ACK state leaves at the fall that ends the ninth pulse. ST_ADDR_ACK goes to ST_HDR. ST_HDR_ACK goes back to ST_HDR, or to ST_DATA after the last header byte. ST_DATA_ACK goes to ST_DATA.
- ST_HDR and ST_DATA move to their ACK state at the fall after the eighth bit.

Top module: `clkgate_i2c_ctrl`

## Requirements
- R1: After reset all seven outputs follow the reference clock and the data line is not driven.
- R2: Bytes arrive MSB first. The address byte 0xD2 (7-bit address 0x69, R/W bit 0 = write) is acknowledged by holding the data line low while the serial clock is high in the ninth pulse.
- R3: An address byte other than 0xD2, including 0xD3 (R/W = 1, read), is not acknowledged. Later bytes up to the next start are neither acknowledged nor stored.
- R4: The two bytes after the address are acknowledged and their contents are ignored. A transfer that stops before the first data byte changes no output.
- R5: The first data byte loads control byte 0 and the second loads control byte 1. Output 0, 1 and 2 take byte 0 bits 2, 3 and 7. Output 3, 4, 5 and 6 take byte 1 bits 2, 3, 6 and 7.
- R6: A transfer carrying only one data byte leaves control byte 1 unchanged.
- R7: Data bytes after the second are acknowledged and discarded.
- R8: An output whose bit is 1 copies the reference clock. An output whose bit is 0 stays low for the whole reference period. The gate changes only while the reference clock is low.
- R9: Reserved control bits (byte 0 bits 0, 1, 4, 5, 6 and byte 1 bits 0, 1, 4, 5) affect no output.
- R10: A repeated start restarts address decoding, and the next data byte loads control byte 0 again.
- R11: The acknowledge is asserted and released only while the serial clock is low, and control registers change only while the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge) |
| ref_clk | input | 1 | Reference clock to be buffered |
| clk_out | output | 7 | Gated copies of the reference clock |

## Verification
A wrong receiver state shows on the data line within one byte. The acknowledge then goes missing, lands in the wrong bit slot, or appears after a rejected address. A byte counter that is out of step loads the wrong control byte. That shows on the gated outputs a few reference periods after the stop, because each output is sampled during both halves of the reference period. A gate flop that follows the wrong edge or the wrong bit shows as a high level in the low half, or as a missing high in the high half.

// File: rtl/clkgate_i2c_pkg.sv
package clkgate_i2c_pkg;

    localparam int NUM_OUT = 7;

    // flat index (byte*8 + bit) of the control bit driving each output
    localparam int OUT_SEL [NUM_OUT] = '{2, 3, 7, 10, 11, 14, 15};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_HDR,
        ST_HDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } rx_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt,
    output logic sda_bit
);

    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;
    logic              sda_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_d <= scl_q[STAGES-1];
            sda_d <= sda_q[STAGES-1];
        end
    end

    assign scl_s     = scl_q[STAGES-1];
    assign sda_s     = sda_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
    assign sda_bit   = sda_s;

endmodule

// File: rtl/i2c_wr_fsm.sv
module i2c_wr_fsm
    import clkgate_i2c_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR  = 7'h69,
    parameter int unsigned HDR_BYTES = 2,
    parameter int unsigned CTL_BYTES = 2,
    localparam int unsigned IDX_W    = $clog2(CTL_BYTES + 1),
    localparam int unsigned HDR_W    = $clog2(HDR_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_evt,
    input  logic             stop_evt,
    input  logic             sda_bit,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data
);

    localparam logic [7:0]       ADDR_WR  = {DEV_ADDR, 1'b0};
    localparam logic [HDR_W-1:0] HDR_LAST = HDR_W'(HDR_BYTES - 1);
    localparam logic [IDX_W-1:0] IDX_MAX  = IDX_W'(CTL_BYTES);

    rx_state_e        state;
    rx_state_e        nxt;
    logic [3:0]       bit_cnt;
    logic [7:0]       shift_q;
    logic [HDR_W-1:0] hdr_cnt;
    logic [IDX_W-1:0] data_idx;
    logic             byte_full;
    logic             in_recv;
    logic             in_ack;

    assign byte_full = (bit_cnt == 4'd8);
    assign in_recv   = (state == ST_ADDR) || (state == ST_HDR) || (state == ST_DATA);
    assign in_ack    = (state == ST_ADDR_ACK) || (state == ST_HDR_ACK) ||
                       (state == ST_DATA_ACK);

    // next-state logic
    always_comb begin
        nxt = state;
        if (start_evt) begin
            nxt = ST_ADDR;
        end else if (stop_evt) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (scl_fall && byte_full)
                                 nxt = (shift_q == ADDR_WR) ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK: if (scl_fall) nxt = ST_HDR;
                ST_HDR:      if (scl_fall && byte_full) nxt = ST_HDR_ACK;
                ST_HDR_ACK:  if (scl_fall) nxt = (hdr_cnt == HDR_LAST) ? ST_DATA : ST_HDR;
                ST_DATA:     if (scl_fall && byte_full) nxt = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall) nxt = ST_DATA;
                ST_SKIP:     nxt = ST_SKIP;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shift_q  <= '0;
            hdr_cnt  <= '0;
            data_idx <= '0;
        end else if (start_evt) begin
            bit_cnt  <= '0;
            hdr_cnt  <= '0;
            data_idx <= '0;
        end else begin
            if (in_recv && scl_rise && !byte_full) begin
                shift_q <= {shift_q[6:0], sda_bit};
                bit_cnt <= bit_cnt + 4'd1;
            end
            if (in_ack && scl_fall) begin
                bit_cnt <= '0;
            end
            if (state == ST_ADDR_ACK && scl_fall) begin
                hdr_cnt <= '0;
            end
            if (state == ST_HDR_ACK && scl_fall) begin
                hdr_cnt <= hdr_cnt + 1'b1;
            end
            if (wr_en) begin
                data_idx <= data_idx + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe  = in_ack;
        wr_en   = (state == ST_DATA) && scl_fall && byte_full &&
                  !start_evt && !stop_evt && (data_idx < IDX_MAX);
        wr_idx  = data_idx;
        wr_data = shift_q;
    end

endmodule

// File: rtl/ctl_regs.sv
module ctl_regs
    import clkgate_i2c_pkg::*;
#(
    parameter int unsigned CTL_BYTES = 2,
    localparam int unsigned IDX_W    = $clog2(CTL_BYTES + 1),
    localparam int unsigned CTL_W    = CTL_BYTES * 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [7:0]         wr_data,
    output logic [CTL_W-1:0]   bytes_q,
    output logic [NUM_OUT-1:0] en_o
);

    for (genvar b = 0; b < CTL_BYTES; b++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bytes_q[b*8 +: 8] <= 8'hFF;
            end else if (wr_en && (wr_idx == IDX_W'(b))) begin
                bytes_q[b*8 +: 8] <= wr_data;
            end
        end
    end

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_map
        assign en_o[i] = bytes_q[OUT_SEL[i]];
    end

endmodule

// File: rtl/clkgate_cell.sv
module clkgate_cell #(
    parameter int unsigned SYNC = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic en_i,
    output logic gate_o,
    output logic clk_o
);

    logic [SYNC-1:0] sync_q;
    logic            gate_q;

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC-2:0], en_i};
    end

    // gate moves only on the falling edge, while the clock is low
    always_ff @(negedge ref_clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b1;
        else        gate_q <= sync_q[SYNC-1];
    end

    assign gate_o = gate_q;
    assign clk_o  = ref_clk & gate_q;

endmodule

// File: rtl/clkgate_i2c_ctrl.sv
module clkgate_i2c_ctrl
    import clkgate_i2c_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR  = 7'h69,
    parameter int unsigned HDR_BYTES = 2,
    parameter int unsigned CTL_BYTES = 2,
    parameter int unsigned IN_SYNC   = 2,
    parameter int unsigned OUT_SYNC  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic               ref_clk,
    output logic [NUM_OUT-1:0] clk_out
);

    localparam int unsigned IDX_W = $clog2(CTL_BYTES + 1);
    localparam int unsigned CTL_W = CTL_BYTES * 8;

    logic               scl_rise;
    logic               scl_fall;
    logic               start_evt;
    logic               stop_evt;
    logic               sda_bit;
    logic               wr_en;
    logic [IDX_W-1:0]   wr_idx;
    logic [7:0]         wr_data;
    logic [CTL_W-1:0]   ctl_bytes;
    logic [NUM_OUT-1:0] en_bits;
    logic [NUM_OUT-1:0] gate_en;

    i2c_line_sync #(.STAGES(IN_SYNC)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .sda_bit   (sda_bit)
    );

    i2c_wr_fsm #(
        .DEV_ADDR  (DEV_ADDR),
        .HDR_BYTES (HDR_BYTES),
        .CTL_BYTES (CTL_BYTES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .sda_bit   (sda_bit),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    ctl_regs #(.CTL_BYTES(CTL_BYTES)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .bytes_q (ctl_bytes),
        .en_o    (en_bits)
    );

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        clkgate_cell #(.SYNC(OUT_SYNC)) u_cell (
            .ref_clk (ref_clk),
            .rst_n   (rst_n),
            .en_i    (en_bits[i]),
            .gate_o  (gate_en[i]),
            .clk_o   (clk_out[i])
        );
    end

endmodule

// File: rtl/clkgate_i2c_chk.sv
module clkgate_i2c_chk #(
    parameter int unsigned CTL_W = 16,
    parameter int unsigned N_OUT = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_i,
    input logic             sda_oe,
    input logic             ref_clk,
    input logic [CTL_W-1:0] ctl_bytes,
    input logic [N_OUT-1:0] gate_en
);

    AST_ACK_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i); // R11

    AST_ACK_FALL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_i); // R11

    AST_REG_UPDATE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_bytes) |-> !scl_i); // R11

    AST_REG_UPDATE_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_bytes) |-> sda_oe); // R5

    AST_GATE_MOVES_REF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gate_en) |-> !ref_clk); // R8

endmodule

bind clkgate_i2c_ctrl clkgate_i2c_chk #(
    .CTL_W (CTL_BYTES * 8),
    .N_OUT (clkgate_i2c_pkg::NUM_OUT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .ref_clk   (ref_clk),
    .ctl_bytes (ctl_bytes),
    .gate_en   (gate_en)
);

// File: tb/sim_clkgate_i2c_ctrl.sv
`timescale 1ns/1ps
module sim_clkgate_i2c_ctrl;

    localparam time Q = 24ns;

    logic       clk = 1'b0;
    logic       ref_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic [6:0] clk_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #2ns clk = ~clk;
    initial begin
        #3ns;
        forever #10ns ref_clk = ~ref_clk;
    end

    clkgate_i2c_ctrl u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl),
        .sda_i   (sda_line),
        .sda_oe  (sda_oe),
        .ref_clk (ref_clk),
        .clk_out (clk_out)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected enable vector from the two control bytes (mapping of R5)
    function automatic logic [6:0] map_en(input logic [7:0] b0, input logic [7:0] b1);
        return {b1[7], b1[6], b1[3], b1[2], b0[7], b0[3], b0[2]};
    endfunction

    // control bytes carrying enables ev, reserved bits filled with junk
    function automatic logic [7:0] mk_b0(input logic [6:0] ev, input logic [7:0] junk);
        return (junk & 8'b0111_0011) | {ev[2], 3'b000, ev[1], ev[0], 2'b00};
    endfunction
    function automatic logic [7:0] mk_b1(input logic [6:0] ev, input logic [7:0] junk);
        return (junk & 8'b0011_0011) | {ev[6], ev[5], 2'b00, ev[4], ev[3], 2'b00};
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; #Q;
        scl = 1'b1;   #Q;
        sda_m = 1'b0; #Q;
        scl = 1'b0;   #Q;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; #Q;
        scl = 1'b1;   #Q;
        sda_m = 1'b1; #Q;
    endtask

    task automatic send_byte(input logic [7:0] d, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = d[i]; #Q;
            scl = 1'b1;   #(2*Q);
            scl = 1'b0;   #Q;
        end
        sda_m = 1'b1; #Q;
        scl = 1'b1;   #Q;
        ack = (sda_line == 1'b0);
        #Q;
        scl = 1'b0;   #Q;
        chk(sda_oe == 1'b0, "R11 ack released after ninth pulse", 16'(sda_oe), 16'h0);
    endtask

    // full transfer: address, two headers, n data bytes; returns acks
    task automatic xfer(input logic [7:0] addr, input int n, input logic [7:0] d0,
                        input logic [7:0] d1, input logic [7:0] d2, output logic [5:0] acks);
        bit a;
        acks = '0;
        bus_start();
        send_byte(addr, a);   acks[0] = a;
        send_byte(8'hA5, a);  acks[1] = a;
        send_byte(8'h5A, a);  acks[2] = a;
        if (n > 0) begin send_byte(d0, a); acks[3] = a; end
        if (n > 1) begin send_byte(d1, a); acks[4] = a; end
        if (n > 2) begin send_byte(d2, a); acks[5] = a; end
        bus_stop();
    endtask

    // sample outputs in the high and the low half of two reference periods
    task automatic chk_out(input logic [6:0] exp, input string req);
        repeat (6) @(posedge ref_clk);
        for (int k = 0; k < 2; k++) begin
            @(posedge ref_clk); #5ns;
            chk(clk_out == exp, req, 16'(clk_out), 16'(exp));
            @(negedge ref_clk); #5ns;
            chk(clk_out == 7'h00, "R8 disabled and enabled outputs low in low half",
                16'(clk_out), 16'h0);
        end
    endtask

    initial begin
        logic [5:0] acks;
        logic [6:0] cur;
        bit         a;
        #1ns;
        #40ns rst_n = 1'b1;
        #40ns;
        chk(sda_oe == 1'b0, "R1 data line released after reset", 16'(sda_oe), 16'h0);
        chk_out(7'h7F, "R1 all outputs running after reset");
        cur = 7'h7F;

        // R2 R4 R5: plain write
        xfer(8'hD2, 2, mk_b0(7'h55, 8'h00), mk_b1(7'h55, 8'h00), 8'h00, acks);
        chk(acks[2:0] == 3'b111, "R2 R4 address and header acked", 16'(acks), 16'h7);
        chk(acks[4:3] == 2'b11, "R5 data bytes acked", 16'(acks), 16'h18);
        cur = 7'h55;
        chk_out(cur, "R5 byte mapping pattern 55");

        // R5 R9 sweep of enable patterns with varied reserved bits
        for (int k = 0; k < 24; k++) begin
            logic [6:0] ev;
            logic [7:0] j;
            ev = 7'((k * 37 + 5) & 127);
            j  = 8'((k * 73) ^ 8'hC3);
            xfer(8'hD2, 2, mk_b0(ev, j), mk_b1(ev, ~j), 8'h00, acks);
            cur = map_en(mk_b0(ev, j), mk_b1(ev, ~j));
            chk(cur == ev, "R9 reserved bits excluded from mapping", 16'(cur), 16'(ev));
            chk_out(cur, "R5 R9 sweep pattern");
        end

        // R8 walking single enable
        for (int i = 0; i < 7; i++) begin
            logic [6:0] ev;
            ev = 7'(1 << i);
            xfer(8'hD2, 2, mk_b0(ev, 8'h00), mk_b1(ev, 8'h00), 8'h00, acks);
            cur = ev;
            chk_out(cur, "R8 single output enabled");
        end

        // R6 partial write keeps byte 1
        xfer(8'hD2, 2, 8'hFF, 8'hFF, 8'h00, acks);
        xfer(8'hD2, 1, 8'h00, 8'h00, 8'h00, acks);
        cur = 7'b1111000;
        chk_out(cur, "R6 only byte 0 updated");

        // R3 wrong address
        xfer(8'hD4, 2, 8'h00, 8'h00, 8'h00, acks);
        chk(acks == 6'b0, "R3 wrong address not acked", 16'(acks), 16'h0);
        chk_out(cur, "R3 wrong address changes nothing");

        // R3 read request
        xfer(8'hD3, 2, 8'hFF, 8'hFF, 8'h00, acks);
        chk(acks == 6'b0, "R3 read bit not acked", 16'(acks), 16'h0);
        chk_out(cur, "R3 read request changes nothing");

        // R7 third data byte acked and dropped
        xfer(8'hD2, 3, mk_b0(7'h0F, 8'h00), mk_b1(7'h0F, 8'h00), 8'h00, acks);
        chk(acks[5] == 1'b1, "R7 extra byte acked", 16'(acks), 16'h3F);
        cur = 7'h0F;
        chk_out(cur, "R7 extra byte discarded");

        // R4 stop after headers only
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        send_byte(8'h00, a);
        bus_stop();
        chk_out(cur, "R4 header-only transfer changes nothing");

        // R10 repeated start restarts decoding and byte index
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        send_byte(8'hFF, a);
        bus_start();
        send_byte(8'hD2, a);
        chk(a == 1'b1, "R10 address acked after repeated start", 16'(a), 16'h1);
        send_byte(8'h33, a);
        send_byte(8'h44, a);
        send_byte(mk_b0(7'h30, 8'h00), a);
        send_byte(mk_b1(7'h30, 8'h00), a);
        bus_stop();
        cur = 7'h30;
        chk_out(cur, "R10 load restarts at byte 0");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #700us;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule